// File: doc/BRIEF.md
# Thermal Throttle Controller

This block watches a stream of digital temperature samples and compares each valid one against a programmable hot threshold. When a sample reaches the threshold, it pulls an active-low hot line. It then drives the throttling outputs that the rest of the chip acts on.

The first throttling mode is a simple throttle-active flag. Software can also force this flag with an on-demand request. The second mode asks the clock and supply logic to step down. It requests a frequency reduction first and a voltage reduction one cycle later, and it undoes the two steps in the reverse order. Only real heat can start the second mode, never the on-demand request.

Each edge of the hot condition can raise a one-cycle interrupt, and each edge has its own enable. A far higher reading sets a catastrophic trip output that stays set until reset. That reading is a fixed offset above the hot threshold.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: While reset is held and after it is released with no samples, hot_n is 1 (released), and throttle_active, freq_reduce, volt_reduce, irq_pulse and trip are 0.
- R2: A valid sample with temp_val >= hot_thresh drives hot_n to 0 from the clock edge that takes it, whatever the mode enables are.
- R3: Once hot, hot_n stays 0 for valid samples down to hot_thresh - HYST. It returns to 1 only on a valid sample with temp_val + HYST < hot_thresh.
- R4: throttle_active is 1 exactly when (mode1_en and hot) or ondemand_req.
- R5: ondemand_req never raises freq_reduce or volt_reduce.
- R6: With mode2_en set, freq_reduce rises one cycle after hot is seen, and volt_reduce rises one cycle after freq_reduce.
- R7: When the second mode ends, volt_reduce falls one cycle before freq_reduce falls.
- R8: When irq_rise_en is 1, a 0-to-1 change of hot gives irq_pulse high for exactly one cycle. When it is 0, that change gives no pulse.
- R9: When irq_fall_en is 1, a 1-to-0 change of hot gives irq_pulse high for exactly one cycle. When it is 0, that change gives no pulse.
- R10: A valid sample with temp_val >= hot_thresh + TRIP_OFFSET sets trip. trip stays 1 through cooler samples and clears only on reset. A sum above the sample range can never trip.
- R11: temp_val is ignored while temp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_valid | input | 1 | Strobe that qualifies temp_val |
| temp_val | input | TEMP_W | Temperature sample, unsigned |
| hot_thresh | input | TEMP_W | Hot threshold, unsigned |
| mode1_en | input | 1 | Enable for the flag throttling mode |
| mode2_en | input | 1 | Enable for the frequency/voltage stepping mode |
| ondemand_req | input | 1 | Software request that forces the flag mode |
| irq_rise_en | input | 1 | Interrupt enable for hot assertion |
| irq_fall_en | input | 1 | Interrupt enable for hot deassertion |
| hot_n | output | 1 | Hot indication: 0 drives the line low, 1 releases it |
| throttle_active | output | 1 | Flag-mode throttle active |
| freq_reduce | output | 1 | Frequency reduction request |
| volt_reduce | output | 1 | Voltage reduction request |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| trip | output | 1 | Sticky catastrophic trip |

## Verification
The bench builds the block with its defaults: TEMP_W = 8, HYST = 2 and TRIP_OFFSET = 20. With the hot threshold at 90, the hysteresis edges sit at 88 and 87, which the bench can sample, and the trip point sits at 110. Raising the threshold to 240 makes the trip sum larger than any 8-bit sample. That lets the bench show that the widened comparison never trips falsely on wrap-around.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
   typedef enum logic [1:0] {
      STEP_IDLE = 2'd0,
      STEP_FREQ = 2'd1,
      STEP_FULL = 2'd2
   } dvfs_step_e;
endpackage

// File: rtl/therm_hot_detect.sv
module therm_hot_detect #(
   parameter int TEMP_W      = 8,
   parameter int HYST        = 2,
   parameter int TRIP_OFFSET = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              temp_valid,
   input  logic [TEMP_W-1:0] temp_val,
   input  logic [TEMP_W-1:0] hot_thresh,
   output logic              hot,
   output logic              trip
);
   localparam int CW = TEMP_W + $clog2(TRIP_OFFSET + HYST + 2) + 1;

   if (TEMP_W < 2)  begin : g_bad_w  $error("TEMP_W too small"); end
   if (HYST < 0)    begin : g_bad_h  $error("HYST negative"); end
   if (TRIP_OFFSET < 1) begin : g_bad_t $error("TRIP_OFFSET must be positive"); end

   logic [CW-1:0] temp_x, thr_x, trip_lvl;
   logic          at_hot, below_band, at_trip;

   assign temp_x   = {{(CW-TEMP_W){1'b0}}, temp_val};
   assign thr_x    = {{(CW-TEMP_W){1'b0}}, hot_thresh};
   assign trip_lvl = thr_x + CW'(TRIP_OFFSET);
   assign at_hot   = temp_x >= thr_x;
   assign at_trip  = temp_x >= trip_lvl;

   if (HYST == 0) begin : g_nohyst
      assign below_band = !at_hot;
   end else begin : g_hyst
      assign below_band = (temp_x + CW'(HYST)) < thr_x;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hot  <= 1'b0;
         trip <= 1'b0;
      end else if (temp_valid) begin
         if (!hot && at_hot)          hot <= 1'b1;
         else if (hot && below_band)  hot <= 1'b0;
         if (at_trip)                 trip <= 1'b1;
      end
   end

   // R2
   hot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      temp_valid && (temp_val >= hot_thresh) |=> hot);
   // R3
   hot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hot && temp_valid && ((temp_x + CW'(HYST)) >= thr_x) |=> hot);
   // R10
   trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trip |=> trip);
   // R11
   no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !temp_valid |=> $stable(hot) && $stable(trip));
endmodule

// File: rtl/therm_dvfs_seq.sv
module therm_dvfs_seq
   import thermal_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic want,
   output logic freq_reduce,
   output logic volt_reduce
);
   dvfs_step_e step_q, step_d;

   always_comb begin
      step_d = step_q;
      unique case (step_q)
         STEP_IDLE: if (want) step_d = STEP_FREQ;
         STEP_FREQ: step_d = want ? STEP_FULL : STEP_IDLE;
         STEP_FULL: if (!want) step_d = STEP_FREQ;
         default:   step_d = STEP_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= STEP_IDLE;
      else        step_q <= step_d;
   end

   assign freq_reduce = (step_q != STEP_IDLE);
   assign volt_reduce = (step_q == STEP_FULL);

   // R6
   volt_after_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(volt_reduce) |-> $past(freq_reduce));
   // R7
   freq_after_volt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(freq_reduce) |-> !$past(volt_reduce));
endmodule

// File: rtl/therm_edge_irq.sv
module therm_edge_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   input  logic rise_en,
   input  logic fall_en,
   output logic pulse
);
   logic level_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_d <= 1'b0;
      else        level_d <= level;
   end

   assign pulse = (rise_en && level && !level_d) || (fall_en && !level && level_d);

   // R8
   pulse_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> (level != level_d));
endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl #(
   parameter int TEMP_W      = 8,
   parameter int HYST        = 2,
   parameter int TRIP_OFFSET = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              temp_valid,
   input  logic [TEMP_W-1:0] temp_val,
   input  logic [TEMP_W-1:0] hot_thresh,
   input  logic              mode1_en,
   input  logic              mode2_en,
   input  logic              ondemand_req,
   input  logic              irq_rise_en,
   input  logic              irq_fall_en,
   output logic              hot_n,
   output logic              throttle_active,
   output logic              freq_reduce,
   output logic              volt_reduce,
   output logic              irq_pulse,
   output logic              trip
);
   logic hot;

   therm_hot_detect #(.TEMP_W(TEMP_W), .HYST(HYST), .TRIP_OFFSET(TRIP_OFFSET)) u_det (
      .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_val(temp_val),
      .hot_thresh(hot_thresh), .hot(hot), .trip(trip));

   therm_dvfs_seq u_seq (
      .clk(clk), .rst_n(rst_n), .want(mode2_en && hot),
      .freq_reduce(freq_reduce), .volt_reduce(volt_reduce));

   therm_edge_irq u_irq (
      .clk(clk), .rst_n(rst_n), .level(hot), .rise_en(irq_rise_en),
      .fall_en(irq_fall_en), .pulse(irq_pulse));

   assign hot_n           = !hot;
   assign throttle_active = (mode1_en && hot) || ondemand_req;

   // R5
   ondemand_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !freq_reduce && !(mode2_en && hot) |=> !freq_reduce);
   // R4
   flag_tracks_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode1_en && !ondemand_req |-> (throttle_active == !hot_n));
endmodule

// File: tb/tb_thermal_throttle_ctrl.sv
module tb_thermal_throttle_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       temp_valid = 1'b0;
   logic [7:0] temp_val = 8'd0;
   logic [7:0] hot_thresh = 8'd90;
   logic       mode1_en = 1'b0, mode2_en = 1'b0, ondemand_req = 1'b0;
   logic       irq_rise_en = 1'b0, irq_fall_en = 1'b0;
   logic       hot_n, throttle_active, freq_reduce, volt_reduce, irq_pulse, trip;
   int         n_run = 0, n_fail = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   thermal_throttle_ctrl dut (
      .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_val(temp_val),
      .hot_thresh(hot_thresh), .mode1_en(mode1_en), .mode2_en(mode2_en),
      .ondemand_req(ondemand_req), .irq_rise_en(irq_rise_en), .irq_fall_en(irq_fall_en),
      .hot_n(hot_n), .throttle_active(throttle_active), .freq_reduce(freq_reduce),
      .volt_reduce(volt_reduce), .irq_pulse(irq_pulse), .trip(trip));

   task automatic chk(input string tag, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic apply(input logic [7:0] t);
      temp_val   = t;
      temp_valid = 1'b1;
      tick();
      temp_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_reset();
      chk("R1 hot_n", hot_n, 1'b1);
      chk("R1 throttle_active", throttle_active, 1'b0);
      chk("R1 freq_reduce", freq_reduce, 1'b0);
      chk("R1 volt_reduce", volt_reduce, 1'b0);
      chk("R1 irq_pulse", irq_pulse, 1'b0);
      chk("R1 trip", trip, 1'b0);
   endtask

   task automatic t_hot_no_mode();
      temp_val = 8'd120; temp_valid = 1'b0;
      tick(); tick();
      chk("R11 hot_n invalid sample", hot_n, 1'b1);
      chk("R11 trip invalid sample", trip, 1'b0);
      apply(8'd90);
      chk("R2 hot_n at threshold, modes off", hot_n, 1'b0);
      chk("R4 flag off with mode1 disabled", throttle_active, 1'b0);
      tick();
      chk("R2 no step with mode2 off", freq_reduce, 1'b0);
      apply(8'd40);
      chk("R2 hot cleared", hot_n, 1'b1);
   endtask

   task automatic t_hyst();
      apply(8'd90);
      apply(8'd89);
      chk("R3 hold at thr-1", hot_n, 1'b0);
      apply(8'd88);
      chk("R3 hold at thr-HYST", hot_n, 1'b0);
      apply(8'd87);
      chk("R3 clear below band", hot_n, 1'b1);
      apply(8'd89);
      chk("R3 no re-assert below thr", hot_n, 1'b1);
   endtask

   task automatic t_mode1();
      mode1_en = 1'b1;
      apply(8'd92);
      chk("R4 flag with hot", throttle_active, 1'b1);
      apply(8'd70);
      chk("R4 flag drops with hot", throttle_active, 1'b0);
      mode1_en = 1'b0;
   endtask

   task automatic t_ondemand();
      mode2_en = 1'b1; ondemand_req = 1'b1;
      tick();
      chk("R4 on-demand flag", throttle_active, 1'b1);
      tick(); tick();
      chk("R5 no freq on-demand", freq_reduce, 1'b0);
      chk("R5 no volt on-demand", volt_reduce, 1'b0);
      ondemand_req = 1'b0;
      tick();
      chk("R4 flag off after on-demand", throttle_active, 1'b0);
      mode2_en = 1'b0;
   endtask

   task automatic t_mode2();
      mode2_en = 1'b1;
      apply(8'd91);
      chk("R6 freq not yet", freq_reduce, 1'b0);
      tick();
      chk("R6 freq first", freq_reduce, 1'b1);
      chk("R6 volt later", volt_reduce, 1'b0);
      tick();
      chk("R6 volt second", volt_reduce, 1'b1);
      apply(8'd60);
      chk("R7 still full", volt_reduce, 1'b1);
      tick();
      chk("R7 volt restored first", volt_reduce, 1'b0);
      chk("R7 freq still reduced", freq_reduce, 1'b1);
      tick();
      chk("R7 freq restored", freq_reduce, 1'b0);
      mode2_en = 1'b0;
   endtask

   task automatic t_irq();
      irq_rise_en = 1'b1; irq_fall_en = 1'b0;
      apply(8'd90);
      chk("R8 rise pulse", irq_pulse, 1'b1);
      tick();
      chk("R8 pulse single cycle", irq_pulse, 1'b0);
      apply(8'd50);
      chk("R9 fall masked", irq_pulse, 1'b0);
      irq_rise_en = 1'b0; irq_fall_en = 1'b1;
      apply(8'd90);
      chk("R8 rise masked", irq_pulse, 1'b0);
      apply(8'd50);
      chk("R9 fall pulse", irq_pulse, 1'b1);
      tick();
      chk("R9 pulse single cycle", irq_pulse, 1'b0);
      irq_fall_en = 1'b0;
   endtask

   task automatic t_trip();
      hot_thresh = 8'd240;
      apply(8'd255);
      chk("R10 no wrap trip", trip, 1'b0);
      chk("R2 hot at high thr", hot_n, 1'b0);
      apply(8'd30);
      hot_thresh = 8'd90;
      apply(8'd109);
      chk("R10 below trip", trip, 1'b0);
      apply(8'd110);
      chk("R10 trip at offset", trip, 1'b1);
      apply(8'd30);
      tick();
      chk("R10 trip sticky", trip, 1'b1);
      do_reset();
      chk("R10 reset clears trip", trip, 1'b0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      tick(); tick();
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_hot_no_mode();
      t_hyst();
      t_mode1();
      t_ondemand();
      t_mode2();
      t_irq();
      t_trip();
      finish_run();
   end

   initial begin
      #(8 * 200000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end
endmodule